// File: doc/BRIEF.md
# Debug Port Register Bank

This block sits behind the serial wire engine of a debug port. It receives one decoded request per cycle: a port select bit (debug-port register or access-port register), a read/write bit, a two-bit register address and write data. One cycle later it answers with a one-hot response code and the read data. Requests to the debug-port side are handled locally: the identification value, the abort register, a control/status register, a wire control register, the port select register, a read-resend register and a read buffer.

Access-port requests are not carried out at once. They go into a one-entry write buffer, which drives a simple valid/ready handshake toward the access port. A read at the access port is posted. The data returned for an access-port read is the result captured from the previous access-port read. The fresh result can be fetched from the read buffer without starting a new transfer. While the buffer holds an entry, only a small set of debug-port accesses is accepted, and every other request is told to wait. The access port can flag an error as a transfer drains. That sets a sticky flag, which makes later access-port requests fail until an abort write clears it.

The buffer is controlled by a two-state machine. In `WB_EMPTY` no transfer is outstanding. An accepted access-port request causes the transition push, `WB_EMPTY` to `WB_HELD`. In `WB_HELD` the handshake request is asserted. When the access port asserts ready, the transition drain returns the machine to `WB_EMPTY`. The read data is captured if the drained transfer was a read without error.

Top module: `dp_regbank`

## Requirements
- R1: A debug-port read at address 0 returns the IDCODE parameter (default 0x0BB11477) with response OK.
- R2: Address 1 reaches the control/status register when bit 0 of the select register is 0, and the wire control register when that bit is 1.
- R3: Control/status layout is as follows. Bit 0 is the debug power-up request and bit 2 is the system power-up request; both are writable and drive `dbg_pwr_req` and `sys_pwr_req`. Bits 1 and 3 read the `dbg_pwr_ack` and `sys_pwr_ack` inputs. Bit 5 reads the sticky error flag. All other bits read 0.
- R4: A debug-port write at address 2 loads the select register. Its bits 31:24 appear on `ap_req_sel`, and its bits 7:4 form `ap_req_addr[5:2]` above the request's two address bits.
- R5: An access-port read returns with OK the value most recently captured from an access-port read, and queues a new read.
- R6: A debug-port read at address 3 returns the captured access-port read result and issues no access-port request.
- R7: A debug-port read at address 2 returns the data of the most recent read that was answered with OK.
- R8: While the write buffer is full, only debug-port requests at address 0 (identification read, abort write) and a control/status read are answered OK. Every other request gets WAIT and has no effect.
- R9: The write buffer holds one transfer. It keeps `ap_req_*` stable until `ap_ready`, and is empty in the cycle after `ap_ready`. Whether a request is accepted depends on the buffer state at the start of its cycle.
- R10: `ap_ready` with `ap_err` sets the sticky flag. While it is set, access-port requests get FAULT and are not queued. A debug-port write at address 0 with write data bit 2 set clears the flag.
- R11: Wire control bits 1:0 hold the turnaround field. The field reads back at those bits and drives `trn_len`, where the value plus one is the turnaround in bit times.
- R12: Every request is answered in the next cycle with `rsp_valid` high and `rsp_ack` one-hot: 3'b001 OK, 3'b010 WAIT, 3'b100 FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ap | input | 1 | 1: access-port request, 0: debug-port register |
| req_rnw | input | 1 | 1: read, 0: write |
| req_addr | input | 2 | Register address bits A[3:2] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ack | output | 3 | One-hot response code |
| rsp_rdata | output | 32 | Read data |
| ap_req_valid | output | 1 | Buffered access-port transfer pending |
| ap_req_rnw | output | 1 | Pending transfer is a read |
| ap_req_sel | output | 8 | Selected access port |
| ap_req_addr | output | 6 | Register window and address |
| ap_req_wdata | output | 32 | Write data of pending transfer |
| ap_ready | input | 1 | Access port completes the pending transfer |
| ap_err | input | 1 | Completion carries an error |
| ap_rdata | input | 32 | Read result, valid with ap_ready |
| dbg_pwr_req | output | 1 | Debug power-up request |
| sys_pwr_req | output | 1 | System power-up request |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge |
| sys_pwr_ack | input | 1 | System power-up acknowledge |
| trn_len | output | 2 | Turnaround field to the wire engine |

## Verification
The draining of the write buffer and the arrival of a new access-port request can fall in the same cycle. The bench holds a transfer in the buffer and raises `ap_ready` in the cycle in which it presents an access-port write. The expected outcome is a WAIT response for the write, no new transfer in the following cycle, and the read data of the drained transfer visible through the read buffer. A second coincidence is also provoked: an error on completion followed by an access-port request. The request must receive FAULT rather than WAIT or OK.

// File: rtl/dp_pkg.sv
package dp_pkg;
    typedef enum logic [2:0] {
        ACK_OK    = 3'b001,
        ACK_WAIT  = 3'b010,
        ACK_FAULT = 3'b100
    } ack_e;

    typedef enum logic {
        WB_EMPTY = 1'b0,
        WB_HELD  = 1'b1
    } wb_state_e;

    localparam logic [1:0] RA_ID  = 2'b00;
    localparam logic [1:0] RA_CS  = 2'b01;
    localparam logic [1:0] RA_SEL = 2'b10;
    localparam logic [1:0] RA_BUF = 2'b11;
endpackage

// File: rtl/dp_wbuf.sv
module dp_wbuf
    import dp_pkg::*;
#(
    parameter int DW   = 32,
    parameter int SELW = 8,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            push_rnw,
    input  logic [SELW-1:0] push_sel,
    input  logic [AW-1:0]   push_addr,
    input  logic [DW-1:0]   push_wdata,
    input  logic            ap_ready,
    input  logic            ap_err,
    input  logic [DW-1:0]   ap_rdata,
    output logic            full,
    output logic            err_seen,
    output logic            ap_req_valid,
    output logic            ap_req_rnw,
    output logic [SELW-1:0] ap_req_sel,
    output logic [AW-1:0]   ap_req_addr,
    output logic [DW-1:0]   ap_req_wdata,
    output logic [DW-1:0]   captured
);
    wb_state_e state_q, state_d;
    logic drain;

    assign drain = (state_q == WB_HELD) && ap_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WB_EMPTY: if (push)     state_d = WB_HELD;
            WB_HELD:  if (ap_ready) state_d = WB_EMPTY;
            default:                state_d = WB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WB_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ap_req_rnw   <= 1'b0;
            ap_req_sel   <= '0;
            ap_req_addr  <= '0;
            ap_req_wdata <= '0;
            captured     <= '0;
        end else begin
            if (push && state_q == WB_EMPTY) begin
                ap_req_rnw   <= push_rnw;
                ap_req_sel   <= push_sel;
                ap_req_addr  <= push_addr;
                ap_req_wdata <= push_wdata;
            end
            if (drain && ap_req_rnw && !ap_err) captured <= ap_rdata;
        end
    end

    assign full         = (state_q == WB_HELD);
    assign ap_req_valid = (state_q == WB_HELD);
    assign err_seen     = drain && ap_err;
endmodule

// File: rtl/dp_cfg_regs.sv
module dp_cfg_regs #(
    parameter int DW   = 32,
    parameter int SELW = 8,
    parameter int BW   = 4,
    parameter int TW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cs,
    input  logic            wr_wire,
    input  logic            wr_sel,
    input  logic            wr_abort,
    input  logic            set_err,
    input  logic [DW-1:0]   wdata,
    output logic            dbg_req,
    output logic            sys_req,
    output logic            sticky,
    output logic            ctrlsel,
    output logic [SELW-1:0] ap_sel,
    output logic [BW-1:0]   bank,
    output logic [TW-1:0]   trn
);
    localparam int SEL_LSB  = DW - SELW;
    localparam int BANK_LSB = 4;
    localparam int CLR_BIT  = 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_req <= 1'b0;
            sys_req <= 1'b0;
            sticky  <= 1'b0;
            ctrlsel <= 1'b0;
            ap_sel  <= '0;
            bank    <= '0;
            trn     <= '0;
        end else begin
            if (wr_cs) begin
                dbg_req <= wdata[0];
                sys_req <= wdata[2];
            end
            if (wr_wire) trn <= wdata[TW-1:0];
            if (wr_sel) begin
                ctrlsel <= wdata[0];
                bank    <= wdata[BANK_LSB +: BW];
                ap_sel  <= wdata[SEL_LSB +: SELW];
            end
            if (set_err)                         sticky <= 1'b1;
            else if (wr_abort && wdata[CLR_BIT]) sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/dp_regbank.sv
module dp_regbank
    import dp_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          SELW   = 8,
    parameter int          BW     = 4,
    parameter int          TW     = 2,
    parameter logic [31:0] IDCODE = 32'h0BB11477
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_ap,
    input  logic            req_rnw,
    input  logic [1:0]      req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic [2:0]      rsp_ack,
    output logic [DW-1:0]   rsp_rdata,
    output logic            ap_req_valid,
    output logic            ap_req_rnw,
    output logic [SELW-1:0] ap_req_sel,
    output logic [BW+1:0]   ap_req_addr,
    output logic [DW-1:0]   ap_req_wdata,
    input  logic            ap_ready,
    input  logic            ap_err,
    input  logic [DW-1:0]   ap_rdata,
    output logic            dbg_pwr_req,
    output logic            sys_pwr_req,
    input  logic            dbg_pwr_ack,
    input  logic            sys_pwr_ack,
    output logic [TW-1:0]   trn_len
);
    localparam int AW = BW + 2;

    logic            wb_full, sticky_err, err_seen, ctrlsel;
    logic [SELW-1:0] cur_sel;
    logic [BW-1:0]   cur_bank;
    logic [DW-1:0]   captured, last_rd, rd_mux, ctrl_word, wire_word;
    ack_e            ack;
    logic            allow_full, acc, dp_wr;

    assign allow_full = !req_ap &&
                        (req_addr == RA_ID || (req_addr == RA_CS && req_rnw && !ctrlsel));

    always_comb begin
        ack = ACK_OK;
        if (wb_full && !allow_full)  ack = ACK_WAIT;
        else if (req_ap && sticky_err) ack = ACK_FAULT;
    end

    assign acc   = req_valid && (ack == ACK_OK);
    assign dp_wr = acc && !req_ap && !req_rnw;

    assign ctrl_word = DW'({sticky_err, 1'b0, sys_pwr_ack, sys_pwr_req,
                            dbg_pwr_ack, dbg_pwr_req});
    assign wire_word = DW'(trn_len);

    always_comb begin
        rd_mux = captured;
        if (!req_ap) begin
            unique case (req_addr)
                RA_ID:   rd_mux = IDCODE[DW-1:0];
                RA_CS:   rd_mux = ctrlsel ? wire_word : ctrl_word;
                RA_SEL:  rd_mux = last_rd;
                RA_BUF:  rd_mux = captured;
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= ACK_OK;
            rsp_rdata <= '0;
            last_rd   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ack   <= ack;
                rsp_rdata <= (acc && req_rnw) ? rd_mux : '0;
            end
            if (acc && req_rnw) last_rd <= rd_mux;
        end
    end

    dp_cfg_regs #(.DW(DW), .SELW(SELW), .BW(BW), .TW(TW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cs    (dp_wr && req_addr == RA_CS && !ctrlsel),
        .wr_wire  (dp_wr && req_addr == RA_CS && ctrlsel),
        .wr_sel   (dp_wr && req_addr == RA_SEL),
        .wr_abort (dp_wr && req_addr == RA_ID),
        .set_err  (err_seen),
        .wdata    (req_wdata),
        .dbg_req  (dbg_pwr_req),
        .sys_req  (sys_pwr_req),
        .sticky   (sticky_err),
        .ctrlsel  (ctrlsel),
        .ap_sel   (cur_sel),
        .bank     (cur_bank),
        .trn      (trn_len)
    );

    dp_wbuf #(.DW(DW), .SELW(SELW), .AW(AW)) u_wbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (acc && req_ap),
        .push_rnw     (req_rnw),
        .push_sel     (cur_sel),
        .push_addr    ({cur_bank, req_addr}),
        .push_wdata   (req_wdata),
        .ap_ready     (ap_ready),
        .ap_err       (ap_err),
        .ap_rdata     (ap_rdata),
        .full         (wb_full),
        .err_seen     (err_seen),
        .ap_req_valid (ap_req_valid),
        .ap_req_rnw   (ap_req_rnw),
        .ap_req_sel   (ap_req_sel),
        .ap_req_addr  (ap_req_addr),
        .ap_req_wdata (ap_req_wdata),
        .captured     (captured)
    );
endmodule

// File: rtl/dp_regbank_chk.sv
module dp_regbank_chk #(
    parameter int          DW     = 32,
    parameter int          BW     = 4,
    parameter logic [31:0] IDCODE = 32'h0BB11477
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ap,
    input logic          req_rnw,
    input logic [1:0]    req_addr,
    input logic          rsp_valid,
    input logic [2:0]    rsp_ack,
    input logic [DW-1:0] rsp_rdata,
    input logic          ap_req_valid,
    input logic          ap_ready,
    input logic [BW+1:0] ap_req_addr,
    input logic [DW-1:0] ap_req_wdata,
    input logic          wb_full,
    input logic          sticky_err
);
    p_idcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ap && req_rnw && req_addr == 2'b00
        |=> rsp_ack == 3'b001 && rsp_rdata == IDCODE[DW-1:0]);

    p_wait_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ap && wb_full |=> rsp_ack == 3'b010);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid && !ap_ready
        |=> ap_req_valid && $stable(ap_req_addr) && $stable(ap_req_wdata));

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req_valid && ap_ready |=> !ap_req_valid);

    p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ap && sticky_err && !wb_full
        |=> rsp_ack == 3'b100 && !ap_req_valid);

    p_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && $countones(rsp_ack) == 1);
endmodule

bind dp_regbank dp_regbank_chk #(.DW(DW), .BW(BW), .IDCODE(IDCODE)) u_chk (.*);

// File: tb/dp_regbank_tb.sv
module dp_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        ap_req_valid, ap_req_rnw;
    logic [7:0]  ap_req_sel;
    logic [5:0]  ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic        ap_ready = 1'b0, ap_err = 1'b0;
    logic [31:0] ap_rdata = '0;
    logic        dbg_pwr_req, sys_pwr_req;
    logic        dbg_pwr_ack = 1'b0, sys_pwr_ack = 1'b0;
    logic [1:0]  trn_len;

    int errors = 0, checks = 0;
    bit done = 0;

    localparam logic [2:0] OK = 3'b001, WT = 3'b010, FT = 3'b100;

    always #2.5 clk = ~clk;

    dp_regbank u_dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [2:0]  r_ack;
    logic [31:0] r_dat;

    task automatic xfer(bit ap, bit rnw, logic [1:0] a, logic [31:0] wd,
                        bit rdy = 0, logic [31:0] rd = '0);
        @(negedge clk);
        req_valid = 1; req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
        ap_ready = rdy; ap_rdata = rd;
        @(negedge clk);
        req_valid = 0; ap_ready = 0;
        r_ack = rsp_ack; r_dat = rsp_rdata;
        chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    endtask

    task automatic drain(logic [31:0] rd, bit err);
        @(negedge clk);
        ap_ready = 1; ap_rdata = rd; ap_err = err;
        @(negedge clk);
        ap_ready = 0; ap_err = 0;
        chk("R9 empty after ready", 32'(ap_req_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R12 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R9 reset ap_req_valid", 32'(ap_req_valid), 0);
        chk("R3 reset pwr req", {30'd0, dbg_pwr_req, sys_pwr_req}, 0);
        chk("R11 reset trn_len", 32'(trn_len), 0);
    endtask

    task automatic t_id;
        xfer(0, 1, 2'b00, 0);
        chk("R1 id ack", 32'(r_ack), 32'(OK));
        chk("R1 id data", r_dat, 32'h0BB11477);
    endtask

    task automatic t_ctrl_wire;
        dbg_pwr_ack = 1; sys_pwr_ack = 0;
        xfer(0, 0, 2'b01, 32'hFFFF_FF05);
        chk("R3 pwr req pins", {30'd0, dbg_pwr_req, sys_pwr_req}, 32'd3);
        xfer(0, 1, 2'b01, 0);
        chk("R3 ctrl readback", r_dat, 32'h7);
        xfer(0, 0, 2'b10, 32'h1);
        xfer(0, 0, 2'b01, 32'h2);
        chk("R11 trn_len", 32'(trn_len), 2);
        chk("R2 ctrl untouched by wire write", 32'(dbg_pwr_req), 1);
        xfer(0, 1, 2'b01, 0);
        chk("R2 R11 wire readback", r_dat, 32'h2);
        xfer(0, 0, 2'b10, 32'h0);
        xfer(0, 1, 2'b01, 0);
        chk("R2 ctrl again", r_dat, 32'h7);
    endtask

    task automatic t_select_full;
        xfer(0, 0, 2'b10, 32'h5A00_0030);
        xfer(1, 0, 2'b01, 32'hDEAD_BEEF);
        chk("R4 ap_req_valid", 32'(ap_req_valid), 1);
        chk("R4 ap_req_sel", 32'(ap_req_sel), 32'h5A);
        chk("R4 ap_req_addr", 32'(ap_req_addr), 32'h0D);
        chk("R4 ap_req_wdata", ap_req_wdata, 32'hDEAD_BEEF);
        xfer(0, 1, 2'b00, 0);
        chk("R8 id while full", 32'(r_ack), 32'(OK));
        xfer(0, 1, 2'b01, 0);
        chk("R8 ctrl read while full", 32'(r_ack), 32'(OK));
        xfer(0, 0, 2'b00, 0);
        chk("R8 abort while full", 32'(r_ack), 32'(OK));
        xfer(1, 1, 2'b00, 0);
        chk("R8 ap read waits", 32'(r_ack), 32'(WT));
        xfer(0, 0, 2'b10, 32'hFF00_0000);
        chk("R8 select write waits", 32'(r_ack), 32'(WT));
        xfer(0, 1, 2'b11, 0);
        chk("R8 rdbuff waits", 32'(r_ack), 32'(WT));
        xfer(0, 0, 2'b01, 32'h0);
        chk("R8 ctrl write waits", 32'(r_ack), 32'(WT));
        chk("R8 ctrl write no effect", 32'(dbg_pwr_req), 1);
        chk("R8 transfer unchanged", 32'(ap_req_sel), 32'h5A);
        drain(32'h0, 0);
    endtask

    task automatic t_posted;
        xfer(1, 1, 2'b00, 0);
        chk("R5 first ap read ack", 32'(r_ack), 32'(OK));
        chk("R5 first ap read data", r_dat, 0);
        drain(32'hCAFE_0001, 0);
        xfer(0, 1, 2'b11, 0);
        chk("R6 rdbuff data", r_dat, 32'hCAFE_0001);
        chk("R6 no ap request", 32'(ap_req_valid), 0);
        xfer(1, 1, 2'b10, 0);
        chk("R5 posted data", r_dat, 32'hCAFE_0001);
        drain(32'h22, 0);
        xfer(0, 1, 2'b10, 0);
        chk("R7 resend", r_dat, 32'hCAFE_0001);
        xfer(0, 1, 2'b11, 0);
        chk("R6 rdbuff new", r_dat, 32'h22);
        xfer(0, 1, 2'b10, 0);
        chk("R7 resend new", r_dat, 32'h22);
    endtask

    task automatic t_sticky;
        xfer(1, 0, 2'b00, 32'h1);
        drain(32'h0, 1);
        xfer(0, 1, 2'b01, 0);
        chk("R10 sticky visible", r_dat, 32'h27);
        xfer(1, 1, 2'b00, 0);
        chk("R10 fault", 32'(r_ack), 32'(FT));
        chk("R10 nothing queued", 32'(ap_req_valid), 0);
        xfer(0, 0, 2'b00, 32'h4);
        xfer(0, 1, 2'b01, 0);
        chk("R10 cleared", r_dat, 32'h7);
        xfer(1, 1, 2'b00, 0);
        chk("R10 ok after abort", 32'(r_ack), 32'(OK));
    endtask

    task automatic t_same_cycle;
        xfer(1, 0, 2'b00, 32'h9, 1, 32'h33);
        chk("R9 request in drain cycle waits", 32'(r_ack), 32'(WT));
        chk("R9 no new transfer", 32'(ap_req_valid), 0);
        xfer(0, 1, 2'b11, 0);
        chk("R9 drained read captured", r_dat, 32'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1;
        t_id;
        t_ctrl_wire;
        t_select_full;
        t_posted;
        t_sticky;
        t_same_cycle;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule